// File: doc/BRIEF.md
# Longitudinal Bang-Bang Bunch Damper

This block decides, bunch by bunch, whether a circulating bunch needs a longitudinal correction. Each sample that arrives carries one bunch's phase word and its slot number. The block keeps the last seven phase values of every slot in a per-slot history. Together with the incoming sample, that gives eight turns of the same bunch. It forms a weighted sum of those eight values with programmable signed coefficients, at full precision. With coefficients that sum to zero, the result is the rate at which that bunch's phase is drifting.

The sum is compared with two separate thresholds. A result above the upper one gives a forward kick, and a result below the lower one gives a backward kick. Anything in between gives no kick. The kick drives a DAC word that is either the programmed amplitude, its negation, or zero.

A turn marker counts revolutions after the enable is raised. No kick is issued until the current turn is the eighth one since enable, which is the first turn in which the history holds only data taken while enabled.

Samples enter on a valid/ready stream and leave on another, one output beat per accepted sample, with a latency of one cycle. The output register holds its beat while the consumer is not ready. The input ready is high exactly when the output register is empty or is being drained in the same cycle, so back-pressure reaches the source without any loss. The bunch slot travels with the beat.

Top module: `lbd_bang_bang`

## Requirements
- R1: After synchronous reset, `out_valid` is 0, `in_ready` is 1 and `out_kick` is 2'b00.
- R2: The derivative is the sum over taps k = 0..7 of coef_k × phase_k, where coef_k is the signed 12-bit field `coef_i[12k+11:12k]` and phase_k is the phase that the same bunch slot carried k accepted samples earlier (k = 0 is the current sample). The sum is kept at 29 bits, so no precision is lost.
- R3: When armed and the derivative is strictly greater than `thr_pos_i`, `out_kick` is 2'b01 and `out_dac` equals +`amp_i`.
- R4: When armed, the derivative is strictly less than `thr_neg_i`, and R3 does not apply, `out_kick` is 2'b10 and `out_dac` equals −`amp_i`.
- R5: A derivative equal to a threshold, or lying between the two thresholds, gives `out_kick` 2'b00 and `out_dac` 0.
- R6: The turn counter clears while `en_i` is low and counts `turn_i` pulses while `en_i` is high. The block is armed only once eight pulses have been seen. While it is not armed, every beat carries code 2'b00 and DAC 0.
- R7: Each bunch slot keeps its own history, so interleaved slots with different phase trends produce independent decisions.
- R8: Each accepted input gives exactly one output beat on the next cycle, carrying the same bunch slot. While `out_valid` is high and `out_ready` is low, the beat stays unchanged and `in_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Damper enable; low clears the turn counter |
| turn_i | input | 1 | One-cycle revolution marker |
| coef_i | input | 96 | Eight signed 12-bit tap weights, tap k at bits 12k+11:12k |
| thr_pos_i | input | 29 | Signed upper threshold |
| thr_neg_i | input | 29 | Signed lower threshold |
| amp_i | input | 13 | Unsigned kick amplitude |
| in_valid | input | 1 | Input sample valid |
| in_ready | output | 1 | Input sample accepted when high together with valid |
| in_bunch | input | 10 | Bunch slot, 0 to 587 |
| in_phase | input | 14 | Signed phase of the bunch |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Consumer ready |
| out_bunch | output | 10 | Bunch slot of the beat |
| out_kick | output | 2 | 00 none, 01 forward, 10 backward |
| out_dac | output | 14 | Signed DAC word: +amp, −amp or 0 |

## Verification
Four interleaved slots are fed twelve turns of contrasting phase patterns: a constant, a rising ramp, a falling ramp at twice the slope, and a ramp too slow to cross the thresholds. This separates forward, backward and no-kick decisions and shows that the slot histories do not mix. Thresholds set exactly at the computed derivative, and then one count inside it, test that both comparisons are strict. A single-tap coefficient setting tests that tap seven really reads the sample taken seven turns earlier. Dropping and re-raising the enable in the middle of a ramp, together with holding the consumer stalled, tests the arming rule and back-pressure.

// File: rtl/lbd_pkg.sv
package lbd_pkg;
  typedef enum logic [1:0] {
    KICK_NONE = 2'b00,
    KICK_FWD  = 2'b01,
    KICK_BACK = 2'b10
  } kick_e;
endpackage

// File: rtl/lbd_history.sv
// Per-slot shift history: one storage array per delay tap, all addressed
// by the same slot index, shifting one step on each write of that slot.
module lbd_history #(
  parameter int NBUNCH = 588,
  parameter int PH_W   = 14,
  parameter int DEPTH  = 7,
  localparam int IDX_W = $clog2(NBUNCH)
) (
  input  logic                    clk,
  input  logic                    wr_en,
  input  logic [IDX_W-1:0]        idx,
  input  logic [PH_W-1:0]         ph_in,
  output logic [DEPTH*PH_W-1:0]   past_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_tap
    logic [PH_W-1:0] mem [0:NBUNCH-1];

    assign past_o[g*PH_W +: PH_W] = mem[idx];

    if (g == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (wr_en) mem[idx] <= ph_in;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (wr_en) mem[idx] <= past_o[(g-1)*PH_W +: PH_W];
      end
    end
  end
endmodule

// File: rtl/lbd_fir.sv
// Full-precision eight-turn weighted sum of one bunch's phase history.
module lbd_fir #(
  parameter int NTAP  = 8,
  parameter int PH_W  = 14,
  parameter int CF_W  = 12,
  localparam int ACC_W = PH_W + CF_W + $clog2(NTAP)
) (
  input  logic [PH_W-1:0]            ph_now,
  input  logic [(NTAP-1)*PH_W-1:0]   past_i,
  input  logic [NTAP*CF_W-1:0]       coef_i,
  output logic signed [ACC_W-1:0]    acc_o
);
  logic [NTAP*PH_W-1:0] taps;
  assign taps = {past_i, ph_now};

  always_comb begin
    logic signed [ACC_W-1:0] sum;
    logic signed [ACC_W-1:0] xe;
    logic signed [ACC_W-1:0] ce;
    sum = '0;
    for (int k = 0; k < NTAP; k++) begin
      xe = {{(ACC_W-PH_W){taps[k*PH_W+PH_W-1]}}, taps[k*PH_W +: PH_W]};
      ce = {{(ACC_W-CF_W){coef_i[k*CF_W+CF_W-1]}}, coef_i[k*CF_W +: CF_W]};
      sum = sum + xe * ce;
    end
    acc_o = sum;
  end
endmodule

// File: rtl/lbd_slicer.sv
// Ternary decision against two thresholds, mapped onto a DAC word.
module lbd_slicer
  import lbd_pkg::*;
#(
  parameter int ACC_W = 29,
  parameter int AMP_W = 13
) (
  input  logic signed [ACC_W-1:0] acc_i,
  input  logic signed [ACC_W-1:0] thr_pos_i,
  input  logic signed [ACC_W-1:0] thr_neg_i,
  input  logic                    armed_i,
  input  logic [AMP_W-1:0]        amp_i,
  output kick_e                   kick_o,
  output logic signed [AMP_W:0]   dac_o
);
  logic signed [AMP_W:0] mag;
  assign mag = {1'b0, amp_i};

  always_comb begin
    kick_o = KICK_NONE;
    dac_o  = '0;
    if (armed_i) begin
      if (acc_i > thr_pos_i) begin
        kick_o = KICK_FWD;
        dac_o  = mag;
      end else if (acc_i < thr_neg_i) begin
        kick_o = KICK_BACK;
        dac_o  = -mag;
      end
    end
  end
endmodule

// File: rtl/lbd_bang_bang.sv
module lbd_bang_bang
  import lbd_pkg::*;
#(
  parameter int NBUNCH = 588,
  parameter int NTAP   = 8,
  parameter int PH_W   = 14,
  parameter int CF_W   = 12,
  parameter int AMP_W  = 13,
  localparam int IDX_W = $clog2(NBUNCH),
  localparam int ACC_W = PH_W + CF_W + $clog2(NTAP),
  localparam int TC_W  = $clog2(NTAP + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en_i,
  input  logic                    turn_i,
  input  logic [NTAP*CF_W-1:0]    coef_i,
  input  logic [ACC_W-1:0]        thr_pos_i,
  input  logic [ACC_W-1:0]        thr_neg_i,
  input  logic [AMP_W-1:0]        amp_i,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [IDX_W-1:0]        in_bunch,
  input  logic [PH_W-1:0]         in_phase,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [IDX_W-1:0]        out_bunch,
  output logic [1:0]              out_kick,
  output logic [AMP_W:0]          out_dac
);
  logic                        accept;
  logic [(NTAP-1)*PH_W-1:0]    past;
  logic signed [ACC_W-1:0]     acc;
  logic [TC_W-1:0]             turns;
  logic                        armed;
  kick_e                       kick_n;
  logic signed [AMP_W:0]       dac_n;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  // Arming: count revolutions since enable, saturating at the filter span.
  always_ff @(posedge clk) begin
    if (rst || !en_i)                          turns <= '0;
    else if (turn_i && turns != TC_W'(NTAP))   turns <= turns + 1'b1;
  end
  assign armed = (turns == TC_W'(NTAP));

  lbd_history #(
    .NBUNCH(NBUNCH), .PH_W(PH_W), .DEPTH(NTAP-1)
  ) u_hist (
    .clk(clk), .wr_en(accept), .idx(in_bunch), .ph_in(in_phase), .past_o(past)
  );

  lbd_fir #(
    .NTAP(NTAP), .PH_W(PH_W), .CF_W(CF_W)
  ) u_fir (
    .ph_now(in_phase), .past_i(past), .coef_i(coef_i), .acc_o(acc)
  );

  lbd_slicer #(
    .ACC_W(ACC_W), .AMP_W(AMP_W)
  ) u_slice (
    .acc_i(acc), .thr_pos_i($signed(thr_pos_i)), .thr_neg_i($signed(thr_neg_i)),
    .armed_i(armed), .amp_i(amp_i), .kick_o(kick_n), .dac_o(dac_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bunch <= '0;
      out_kick  <= KICK_NONE;
      out_dac   <= '0;
    end else if (accept) begin
      out_valid <= 1'b1;
      out_bunch <= in_bunch;
      out_kick  <= kick_n;
      out_dac   <= dac_n;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lbd_bang_bang_chk.sv
module lbd_bang_bang_chk #(
  parameter int IDX_W = 10,
  parameter int AMP_W = 13
) (
  input logic             clk,
  input logic             rst,
  input logic             en_i,
  input logic             in_valid,
  input logic             in_ready,
  input logic [IDX_W-1:0] in_bunch,
  input logic             out_valid,
  input logic             out_ready,
  input logic [IDX_W-1:0] out_bunch,
  input logic [1:0]       out_kick,
  input logic [AMP_W:0]   out_dac
);
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_kick)
                                && $stable(out_dac) && $stable(out_bunch));

  a_r8_one_beat: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid && out_bunch == $past(in_bunch));

  a_r8_stall: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |-> !in_ready);

  a_r5_quiet_dac: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_kick == 2'b00 |-> out_dac == '0);

  a_r3_fwd_sign: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_kick == 2'b01 |-> !out_dac[AMP_W]);

  a_r4_back_sign: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_kick == 2'b10 |-> out_dac[AMP_W] || out_dac == '0);

  a_r6_disabled: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && !en_i |=> out_kick == 2'b00);

  a_r1_legal_code: assert property (@(posedge clk) disable iff (rst)
    out_kick != 2'b11);
endmodule

bind lbd_bang_bang lbd_bang_bang_chk #(.IDX_W(IDX_W), .AMP_W(AMP_W)) u_chk (.*);

// File: tb/lbd_bang_bang_test.sv
`timescale 1ns/1ps
module lbd_bang_bang_test;
  localparam int NB    = 4;
  localparam int IDX_W = $clog2(NB);
  localparam int ACC_W = 29;
  localparam int AMP_W = 13;
  localparam int AMP   = 1000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0, turn = 1'b0;
  logic [95:0] coef;
  logic [ACC_W-1:0] thr_pos, thr_neg;
  logic [AMP_W-1:0] amp;
  logic in_valid = 1'b0, in_ready, out_valid, out_ready = 1'b1;
  logic [IDX_W-1:0] in_bunch = '0, out_bunch;
  logic [13:0] in_phase = '0;
  logic [1:0] out_kick;
  logic [AMP_W:0] out_dac;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  lbd_bang_bang #(.NBUNCH(NB)) uut (
    .clk(clk), .rst(rst), .en_i(en), .turn_i(turn), .coef_i(coef),
    .thr_pos_i(thr_pos), .thr_neg_i(thr_neg), .amp_i(amp),
    .in_valid(in_valid), .in_ready(in_ready), .in_bunch(in_bunch),
    .in_phase(in_phase), .out_valid(out_valid), .out_ready(out_ready),
    .out_bunch(out_bunch), .out_kick(out_kick), .out_dac(out_dac)
  );

  // Rows are turns 1..12; packed {b3,b2,b1,b0}. b0 constant, b1 +10/turn,
  // b2 -20/turn, b3 +1/turn.
  localparam logic [55:0] PH_TBL [12] = '{
    {14'(-300), 14'(2000), 14'(100), 14'(500)},
    {14'(-299), 14'(1980), 14'(110), 14'(500)},
    {14'(-298), 14'(1960), 14'(120), 14'(500)},
    {14'(-297), 14'(1940), 14'(130), 14'(500)},
    {14'(-296), 14'(1920), 14'(140), 14'(500)},
    {14'(-295), 14'(1900), 14'(150), 14'(500)},
    {14'(-294), 14'(1880), 14'(160), 14'(500)},
    {14'(-293), 14'(1860), 14'(170), 14'(500)},
    {14'(-292), 14'(1840), 14'(180), 14'(500)},
    {14'(-291), 14'(1820), 14'(190), 14'(500)},
    {14'(-290), 14'(1800), 14'(200), 14'(500)},
    {14'(-289), 14'(1780), 14'(210), 14'(500)}
  };
  // Expected codes {k3,k2,k1,k0}: unarmed for turns 1..7.
  localparam logic [7:0] KX_TBL [12] = '{
    8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00,
    8'h24, 8'h24, 8'h24, 8'h24, 8'h24
  };

  function automatic logic [95:0] deriv_coef();
    logic [95:0] c;
    int w [8] = '{4, 3, 2, 1, -1, -2, -3, -4};
    for (int k = 0; k < 8; k++) c[k*12 +: 12] = 12'(w[k]);
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_turn();
    @(negedge clk) turn = 1'b1;
    @(negedge clk) turn = 1'b0;
  endtask

  task automatic send(input int b, input logic [13:0] ph, input logic [1:0] ek,
                      input string req);
    int edac;
    @(negedge clk);
    in_valid = 1'b1; in_bunch = IDX_W'(b); in_phase = ph;
    @(negedge clk);
    in_valid = 1'b0;
    edac = (ek == 2'b01) ? AMP : (ek == 2'b10) ? -AMP : 0;
    check(out_valid && out_bunch == IDX_W'(b), "R8", "beat/bunch",
          int'(out_bunch), b);
    check(out_kick == ek, req, "kick", int'(out_kick), int'(ek));
    check($signed(out_dac) == edac, req, "dac", int'($signed(out_dac)), edac);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    coef = deriv_coef();
    thr_pos = ACC_W'(100);
    thr_neg = ACC_W'(-100);
    amp = AMP_W'(AMP);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!out_valid && in_ready && out_kick == 2'b00, "R1", "reset state",
          int'({out_valid, in_ready, out_kick}), 4);

    // Table walk: R2/R3/R4/R5/R6/R7
    en = 1'b1;
    for (int t = 0; t < 12; t++) begin
      pulse_turn();
      for (int b = 0; b < NB; b++) begin
        send(b, PH_TBL[t][b*14 +: 14], KX_TBL[t][b*2 +: 2],
             (t < 7) ? "R6" : (b == 1) ? "R3" : (b == 2) ? "R4" : "R7");
      end
    end

    // Turn 13: thresholds equal to the derivative (+500 / -1000) -> none (R5)
    pulse_turn();
    thr_pos = ACC_W'(500);
    send(1, 14'(220), 2'b00, "R5");
    thr_neg = ACC_W'(-1000);
    send(2, 14'(1760), 2'b00, "R5");
    // Turn 14: one count inside -> kicks (R3, R4)
    pulse_turn();
    thr_pos = ACC_W'(499);
    send(1, 14'(230), 2'b01, "R3");
    thr_neg = ACC_W'(-999);
    send(2, 14'(1740), 2'b10, "R4");

    // Turn 15: only tap 7 weighted -> reads sample of seven turns ago (R2)
    pulse_turn();
    coef = '0;
    coef[84 +: 12] = 12'd1;
    thr_pos = ACC_W'(169);
    thr_neg = ACC_W'(-100);
    send(1, 14'(240), 2'b01, "R2");        // tap7 = 170 > 169
    thr_pos = ACC_W'(1860);
    send(2, 14'(1720), 2'b00, "R2");       // tap7 = 1860, not above
    coef = deriv_coef();
    thr_pos = ACC_W'(100);

    // Back-pressure (R8)
    pulse_turn();
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_bunch = 0; in_phase = 14'(500);
    @(negedge clk);
    in_bunch = 1; in_phase = 14'(77);
    check(out_valid && out_bunch == 0 && out_kick == 2'b00, "R8",
          "stalled beat", int'(out_bunch), 0);
    check(!in_ready, "R8", "in_ready while stalled", int'(in_ready), 0);
    repeat (2) @(negedge clk);
    check(out_valid && out_bunch == 0, "R8", "beat held", int'(out_bunch), 0);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check(!out_valid, "R8", "drained", int'(out_valid), 0);

    // Enable drop on a rising ramp (R6)
    en = 1'b0;
    send(1, 14'(250), 2'b00, "R6");
    en = 1'b1;
    for (int n = 1; n <= 8; n++) begin
      pulse_turn();
      send(1, 14'(250 + 10*n), (n == 8) ? 2'b01 : 2'b00, "R6");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule